// File: doc/BRIEF.md
# Sector Lockdown Status Reader

This block answers one serial read command as a slave on a four-wire SPI bus: it returns a read-only table of per-sector lockdown status bytes. After chip select falls, the master shifts in an 8-bit command code and then three filler bytes that the block ignores. From the falling clock edge after the last filler bit onward, the block shifts out one status byte per sector, starting with sector 0 (which covers both halves of the split first sector). It continues up to the last sector. If the master keeps clocking after that, the block returns all-ones filler.

The status table comes in on a parallel input that some other block owns. The reader only serialises that input. Its three bus inputs pass through synchronisers into the system clock domain, and edges of the serial clock are detected there. The bus therefore has to run well below the system clock. The output driver enable is high only while a valid read is delivering data. It falls once chip select goes high, and a new selection restarts the command decoder from the beginning.

Top module: `sector_lock_reader`

## Requirements
- R1: After reset, and with chip select high, `miso_oe` is 0 and `miso` is 0.
- R2: Only command code 0x35, received MSB first on rising SCK edges, starts a read. `miso_oe` stays 0 through the command byte and the 24 filler bits, and rises only after the 32nd rising SCK edge of the selection.
- R3: Output byte k (k = 0 for sector 0) is `lock_bits[8k+7:8k]`. Bytes go out in increasing sector order, each one MSB first.
- R4: After the NUM_SECTORS defined bytes, every further bit is 1, so each further byte reads 0xFF.
- R5: Raising chip select drops `miso_oe` to 0 within the synchroniser latency and aborts any command in progress. The next selection decodes a fresh command.
- R6: In the data phase `miso` changes only after a falling SCK edge. It holds steady while SCK is high, so the master can sample it on the rising edge (mode 0).
- R7: Any command code other than 0x35 keeps `miso_oe` at 0 for the whole selection.
- R8: Each transfer reflects the value of `lock_bits` at the time of that transfer. A changed table is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from master |
| lock_bits | input | NUM_SECTORS*8 | Status table, byte k belongs to sector k |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output driver enable; low means high impedance |

## Verification
The bench watches the enable at every header bit. A design that counts the filler bits wrong would turn the driver on early, or would return the table shifted by a bit. Reads run past the last sector to catch a byte index that wraps back to sector 0 instead of returning 0xFF. The bench sends wrong command codes and aborts selections partway, which exposes a decoder that drives on a bad code or keeps stale header progress into the next selection. It also samples `miso` in the middle of the high half of SCK, which catches data that changes on the rising edge.

// File: rtl/lockrd_pkg.sv
package lockrd_pkg;

    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_FILLER = 2'd1,
        PH_DATA   = 2'd2,
        PH_IGNORE = 2'd3
    } phase_t;

    localparam logic FILL_BIT = 1'b1;

endpackage

// File: rtl/lockrd_sync.sv
module lockrd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RESET_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= din;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/lockrd_edge.sv
module lockrd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

endmodule

// File: rtl/lockrd_bitsel.sv
module lockrd_bitsel
    import lockrd_pkg::*;
#(
    parameter int NUM_SECTORS = 16,
    localparam int DATA_BITS  = NUM_SECTORS * 8,
    localparam int IDX_W      = $clog2(DATA_BITS + 1),
    localparam int SEL_W      = $clog2(DATA_BITS)
) (
    input  logic [DATA_BITS-1:0] lock_bits,
    input  logic [IDX_W-1:0]     bit_idx,
    output logic                 bit_out
);

    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(DATA_BITS);

    logic [IDX_W-1:0] pos;

    always_comb begin
        // byte part kept, bit part mirrored so each byte leaves MSB first
        pos = {bit_idx[IDX_W-1:3], ~bit_idx[2:0]};
        if (bit_idx < END_IDX) bit_out = lock_bits[pos[SEL_W-1:0]];
        else                   bit_out = FILL_BIT;
    end

endmodule

// File: rtl/sector_lock_reader.sv
module sector_lock_reader
    import lockrd_pkg::*;
#(
    parameter int          NUM_SECTORS = 16,
    parameter int          FILLER_BYTES = 3,
    parameter logic [7:0]  READ_OP     = 8'h35,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sck,
    input  logic                     mosi,
    input  logic [NUM_SECTORS*8-1:0] lock_bits,
    output logic                     miso,
    output logic                     miso_oe
);

    localparam int DATA_BITS = NUM_SECTORS * 8;
    localparam int HDR_BITS  = 8 + FILLER_BYTES * 8;
    localparam int HDR_W     = $clog2(HDR_BITS + 1);
    localparam int IDX_W     = $clog2(DATA_BITS + 1);
    localparam logic [HDR_W-1:0] CMD_LAST = HDR_W'(7);
    localparam logic [HDR_W-1:0] HDR_LAST = HDR_W'(HDR_BITS - 1);
    localparam logic [HDR_W-1:0] HDR_DONE = HDR_W'(HDR_BITS);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(DATA_BITS);

    typedef struct packed {
        phase_t           phase;
        logic [7:0]       cmd;
        logic [HDR_W-1:0] hdr;
        logic [IDX_W-1:0] idx;
        logic             miso;
        logic             oe;
    } state_t;

    state_t st_d, st_q;

    logic cs_s, sck_s, mosi_s;
    logic rise, fall;
    logic bit_out;
    logic [7:0] cmd_next;

    lockrd_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, mosi}),
        .dout  ({cs_s, sck_s, mosi_s})
    );

    lockrd_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck_s),
        .rise  (rise),
        .fall  (fall)
    );

    lockrd_bitsel #(
        .NUM_SECTORS (NUM_SECTORS)
    ) u_sel (
        .lock_bits (lock_bits),
        .bit_idx   (st_q.idx),
        .bit_out   (bit_out)
    );

    assign cmd_next = {st_q.cmd[6:0], mosi_s};

    always_comb begin
        st_d = st_q;
        if (cs_s) begin
            st_d.phase = PH_CMD;
            st_d.cmd   = '0;
            st_d.hdr   = '0;
            st_d.idx   = '0;
            st_d.miso  = 1'b0;
            st_d.oe    = 1'b0;
        end else begin
            case (st_q.phase)
                PH_CMD: begin
                    if (rise) begin
                        st_d.cmd = cmd_next;
                        st_d.hdr = st_q.hdr + 1'b1;
                        if (st_q.hdr == CMD_LAST) begin
                            st_d.phase = (cmd_next == READ_OP) ? PH_FILLER : PH_IGNORE;
                        end
                    end
                end
                PH_FILLER: begin
                    if (rise) begin
                        st_d.hdr = st_q.hdr + 1'b1;
                        if (st_q.hdr == HDR_LAST) begin
                            st_d.phase = PH_DATA;
                            st_d.oe    = 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (fall) begin
                        st_d.miso = bit_out;
                        if (st_q.idx != IDX_END) st_d.idx = st_q.idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_CMD, cmd: '0, hdr: '0, idx: '0, miso: 1'b0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign miso    = st_q.miso;
    assign miso_oe = st_q.oe;

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe && !miso);                                          // R1
    AST_OE_AFTER_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> ($past(rise) && st_q.hdr == HDR_DONE));            // R2
    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && fall && st_q.phase == PH_DATA && st_q.idx == IDX_END) |=> miso); // R4
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && miso_oe) |=> !miso_oe);                                      // R5
    AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !fall) |=> $stable(miso));                                  // R6
    AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IGNORE) |-> !miso_oe);                              // R7

endmodule

// File: tb/sector_lock_reader_tb.sv
module sector_lock_reader_tb;

    localparam int NS   = 16;
    localparam int HALF = 6;
    localparam int EXTRA = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic [NS*8-1:0] lock_bits = '0;
    logic miso, miso_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sector_lock_reader u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .mosi      (mosi),
        .lock_bits (lock_bits),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

    // {command code, table seed}
    localparam logic [15:0] VEC [6] = '{
        16'h35A5, 16'h3500, 16'h9F3C, 16'h35FF, 16'h0011, 16'h355A
    };

    function automatic logic [7:0] exp_byte(input logic [7:0] seed, input int k);
        return seed ^ 8'(k * 29) ^ 8'(k << 4);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one SPI bit in mode 0; samples taken before the rise and mid high phase
    task automatic spi_bit(input logic b, output logic pre, output logic oe_pre,
                           output logic mid);
        mosi = b;
        wait_clk(HALF);
        pre = miso;
        oe_pre = miso_oe;
        sck = 1'b1;
        wait_clk(HALF - 1);
        mid = miso;
        wait_clk(1);
        sck = 1'b0;
    endtask

    task automatic read_xfer(input logic [7:0] op, input logic [7:0] seed, input int nbytes);
        logic p, o, m;
        logic [7:0] got;
        int hdr_oe;
        int quiet_bad;
        int unstable;
        bit good;
        good = (op == 8'h35);
        hdr_oe = 0;
        quiet_bad = 0;
        unstable = 0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 32; i++) begin
            spi_bit((i < 8) ? op[7 - i] : 1'b1, p, o, m);
            if (o) hdr_oe++;
        end
        check("R2 enable during header", 32'(hdr_oe), 32'd0);
        for (int k = 0; k < nbytes; k++) begin
            for (int b = 0; b < 8; b++) begin
                spi_bit(1'b0, p, o, m);
                got[7 - b] = p;
                if (good && m !== p) unstable++;
                if (o !== good) quiet_bad++;
            end
            if (good) begin
                if (k < NS) check("R3 R8 sector byte", 32'(got), 32'(exp_byte(seed, k)));
                else        check("R4 fill byte", 32'(got), 32'hFF);
            end
        end
        if (good) begin
            check("R2 enable in data", 32'(quiet_bad), 32'd0);
            check("R6 stable while sck high", 32'(unstable), 32'd0);
        end else begin
            check("R7 enable with bad code", 32'(quiet_bad), 32'd0);
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(5);
        check("R5 enable after deselect", 32'(miso_oe), 32'd0);
        wait_clk(HALF);
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic p, o, m;
        wait_clk(3);
        check("R1 enable in reset", 32'(miso_oe), 32'd0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 enable after reset", 32'(miso_oe), 32'd0);
        check("R1 data after reset", 32'(miso), 32'd0);

        // table-driven reads
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < NS; k++) lock_bits[8*k +: 8] = exp_byte(VEC[r][7:0], k);
            read_xfer(VEC[r][15:8], VEC[r][7:0], NS + EXTRA);
        end

        // abort inside the filler bytes, then a full read must decode afresh
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 20; i++) spi_bit((i < 8) ? 8'h35 >> (7 - i) : 1'b0, p, o, m);
        cs_n = 1'b1;
        wait_clk(5);
        check("R5 enable after abort", 32'(miso_oe), 32'd0);
        wait_clk(HALF);
        for (int k = 0; k < NS; k++) lock_bits[8*k +: 8] = exp_byte(8'hC3, k);
        read_xfer(8'h35, 8'hC3, NS + 4);

        // code differing from the read code in its last bit only
        read_xfer(8'h34, 8'hC3, 2);

        // short read of a few bytes, then a new table is seen (R8)
        for (int k = 0; k < NS; k++) lock_bits[8*k +: 8] = exp_byte(8'h0F, k);
        read_xfer(8'h35, 8'h0F, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule